// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block prepares one active-low external interrupt pin for a small interrupt system. The pin is asynchronous, so it first passes through a chain of synchronizing flops. The synchronized pin then drives one interrupt request in one of two ways. In level mode, the request is high while the pin is low. In edge mode, a falling edge sets a sticky latch, and the latch holds the request until the interrupt service logic acknowledges it.

Software sets the block up through one 8-bit control register on a plain register bus (address, write strobe, write data, combinational read data). The register has two implemented bits. The edge-select bit is protected by a mode input: in normal mode it accepts only the first write after reset, and in special mode it accepts every write. The pin-enable bit can be written at any time in either mode, and clearing it cuts the pin off from the request logic.

Top module: `irqpin_top`

## Requirements
- R1: After reset, reading the control address returns 0x40: bit 7 (edge-select) is 0 and bit 6 (pin-enable) is 1. With the pin held high, `irq_req` is 0.
- R2: Bits 5 to 0 of the control register read as 0, and writes to them are ignored. Any other address reads 0x00, and writes to it change nothing.
- R3: In level mode (bit 7 = 0) with pin-enable set, `irq_req` rises SYNC_STAGES clock edges after the pin goes low. It falls the same number of edges after the pin returns high.
- R4: In edge mode (bit 7 = 1) with pin-enable set, a falling edge of the synchronized pin raises `irq_req` SYNC_STAGES+1 edges after the pin falls. The request then stays high after the pin returns high.
- R5: A one-cycle `irq_ack` clears the edge latch at the next edge. If a new falling edge is detected in the same cycle as the acknowledge, the latch stays set.
- R6: In normal mode (`mode_special` = 0), the first write to the control address sets a lock, even when the written value equals the stored value. While the lock is set, normal-mode writes leave bit 7 unchanged. Only reset clears the lock.
- R7: In special mode (`mode_special` = 1), every write to the control address updates bit 7, even when the lock is set.
- R8: With pin-enable at 0, `irq_req` stays 0 and the edge latch is held clear. Bit 6 is writable in both modes, whether or not the lock is set.
- R9: Leaving edge mode for level mode clears the edge latch. A stale edge therefore does not survive the mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_special | input | 1 | 1 = special mode (bit 7 always writable), 0 = normal mode (bit 7 write-once) |
| reg_addr | input | ADDR_W | Register bus address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from the address |
| pin_n | input | 1 | Asynchronous active-low interrupt pin |
| irq_ack | input | 1 | One-cycle acknowledge that the interrupt was serviced |
| irq_req | output | 1 | Interrupt request to the interrupt controller |

## Verification
The bench uses the default parameters: two synchronizer stages, a 4-bit address and the control register at address 5. The short chain keeps the level and edge latencies at two and three edges. Only with that short chain can the bench land a synchronized falling edge exactly in the acknowledge cycle and test the priority of a new edge over the acknowledge. The 4-bit address space gives the bench a spare address to confirm that a write outside the control register changes nothing.

// File: rtl/irqpin_pkg.sv
package irqpin_pkg;

    localparam int unsigned EDGE_BIT = 7;
    localparam int unsigned EN_BIT   = 6;

    typedef struct packed {
        logic edge_sel;
        logic pin_en;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{edge_sel: 1'b0, pin_en: 1'b1};

    function automatic logic [7:0] ctrl_to_byte(input ctrl_t c);
        logic [7:0] b;
        b = 8'h00;
        b[EDGE_BIT] = c.edge_sel;
        b[EN_BIT]   = c.pin_en;
        return b;
    endfunction

endpackage

// File: rtl/irqpin_sync.sv
module irqpin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[LAST];
endmodule

// File: rtl/irqpin_ctrl_reg.sv
module irqpin_ctrl_reg
    import irqpin_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned CTRL_ADDR = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_special,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output ctrl_t             cfg
);
    localparam logic [ADDR_W-1:0] SEL = ADDR_W'(CTRL_ADDR);

    logic  hit_wr;
    logic  locked;
    logic  unused_low;
    ctrl_t cfg_q;

    assign hit_wr     = reg_we && (reg_addr == SEL);
    assign unused_low = ^reg_wdata[5:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= CTRL_RESET;
            locked <= 1'b0;
        end else if (hit_wr) begin
            cfg_q.pin_en <= reg_wdata[EN_BIT];
            if (mode_special || !locked)
                cfg_q.edge_sel <= reg_wdata[EDGE_BIT];
            if (!mode_special)
                locked <= 1'b1;
        end
    end

    assign cfg       = cfg_q;
    assign reg_rdata = (reg_addr == SEL) ? ctrl_to_byte(cfg_q) : 8'h00;

    // R6: once locked, a normal-mode write keeps edge-select
    a_r6_lock_holds_edge: assert property (@(posedge clk) disable iff (rst)
        (hit_wr && locked && !mode_special) |=> $stable(cfg_q.edge_sel));

    // R7: special-mode write always lands in edge-select
    a_r7_special_writes: assert property (@(posedge clk) disable iff (rst)
        (hit_wr && mode_special) |=> (cfg_q.edge_sel == $past(reg_wdata[EDGE_BIT])));

    // R8: pin-enable follows every write
    a_r8_enable_writable: assert property (@(posedge clk) disable iff (rst)
        hit_wr |=> (cfg_q.pin_en == $past(reg_wdata[EN_BIT])));
endmodule

// File: rtl/irqpin_detect.sv
module irqpin_detect
    import irqpin_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t cfg,
    input  logic  pin_sync,
    input  logic  irq_ack,
    output logic  irq_req
);
    logic prev_q;
    logic fall;
    logic latch_q;
    logic latch_d;

    assign fall = prev_q && !pin_sync;

    always_comb begin
        latch_d = latch_q;
        if (!cfg.pin_en || !cfg.edge_sel) latch_d = 1'b0;
        else if (fall)                    latch_d = 1'b1;
        else if (irq_ack)                 latch_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b1;
            latch_q <= 1'b0;
        end else begin
            prev_q  <= pin_sync;
            latch_q <= latch_d;
        end
    end

    assign irq_req = cfg.pin_en && (cfg.edge_sel ? latch_q : !pin_sync);

    // R4: a detected edge while armed sets the latch
    a_r4_edge_sets: assert property (@(posedge clk) disable iff (rst)
        (cfg.pin_en && cfg.edge_sel && fall) |=> latch_q);

    // R5: acknowledge without a new edge clears the latch
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !fall) |=> !latch_q);

    // R8: disabled pin keeps the latch clear
    a_r8_disabled_clear: assert property (@(posedge clk) disable iff (rst)
        !cfg.pin_en |=> !latch_q);

    // R9: level mode keeps the latch clear
    a_r9_level_clears: assert property (@(posedge clk) disable iff (rst)
        !cfg.edge_sel |=> !latch_q);
endmodule

// File: rtl/irqpin_top.sv
module irqpin_top
    import irqpin_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned CTRL_ADDR   = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_special,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              pin_n,
    input  logic              irq_ack,
    output logic              irq_req
);
    ctrl_t cfg;
    logic  pin_sync;

    irqpin_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_reg (
        .clk(clk), .rst(rst), .mode_special(mode_special),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cfg(cfg)
    );

    irqpin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(pin_n), .sync_out(pin_sync)
    );

    irqpin_detect u_det (
        .clk(clk), .rst(rst), .cfg(cfg), .pin_sync(pin_sync),
        .irq_ack(irq_ack), .irq_req(irq_req)
    );

    // R2: unimplemented bits never read back as 1
    a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[5:0] == 6'b0);
endmodule

// File: tb/test_irqpin_top.sv
module test_irqpin_top;
    localparam int unsigned AW  = 4;
    localparam int unsigned CA  = 5;
    localparam int unsigned STG = 2;

    typedef struct {
        string      tag;
        logic       exp_irq;
        logic       chk_rd;
        logic [7:0] exp_rd;
    } item_t;

    logic          clk = 0;
    logic          rst = 1;
    logic          mode_special = 0;
    logic [AW-1:0] reg_addr = AW'(CA);
    logic          reg_we = 0;
    logic [7:0]    reg_wdata = 0;
    logic [7:0]    reg_rdata;
    logic          pin_n = 1;
    logic          irq_ack = 0;
    logic          irq_req;

    item_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irqpin_top #(.ADDR_W(AW), .CTRL_ADDR(CA), .SYNC_STAGES(STG)) i_irqpin_top (
        .clk(clk), .rst(rst), .mode_special(mode_special),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pin_n(pin_n), .irq_ack(irq_ack), .irq_req(irq_req)
    );

    // monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            wait (q.size() != 0);
            begin
                item_t it;
                it = q.pop_front();
                n_cmp++;
                if (irq_req !== it.exp_irq) begin
                    n_bad++;
                    $display("FAIL %s irq_req got %b exp %b", it.tag, irq_req, it.exp_irq);
                end
                if (it.chk_rd && reg_rdata !== it.exp_rd) begin
                    n_bad++;
                    $display("FAIL %s reg_rdata got %h exp %h", it.tag, reg_rdata, it.exp_rd);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic expect_out(input string tag, input logic irq, input logic chk, input logic [7:0] rd);
        item_t it;
        it.tag = tag; it.exp_irq = irq; it.chk_rd = chk; it.exp_rd = rd;
        q.push_back(it);
        #0.5;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        reg_addr = a; reg_we = 1; reg_wdata = d;
        step(1);
        reg_we = 0; reg_addr = AW'(CA);
    endtask

    task automatic do_reset();
        rst = 1; pin_n = 1; irq_ack = 0; reg_we = 0; mode_special = 0;
        step(2);
        rst = 0;
    endtask

    task automatic ack1();
        irq_ack = 1; step(1); irq_ack = 0;
    endtask

    initial begin
        step(1);
        do_reset();
        // R1 reset state
        expect_out("R1 reset", 1'b0, 1'b1, 8'h40);

        // R2 other address reads zero; write there has no effect
        reg_addr = AW'(CA + 1);
        #0.5;
        expect_out("R2 other addr", 1'b0, 1'b1, 8'h00);
        reg_addr = AW'(CA);
        wr(AW'(CA + 1), 8'hFF);
        expect_out("R2 stray write", 1'b0, 1'b1, 8'h40);

        // R3 level mode latency
        pin_n = 0;
        step(STG - 1);
        expect_out("R3 before latency", 1'b0, 1'b0, 8'h00);
        step(1);
        expect_out("R3 low level", 1'b1, 1'b1, 8'h40);
        pin_n = 1;
        step(STG);
        expect_out("R3 released", 1'b0, 1'b0, 8'h00);

        // R6: first normal write with same value locks; low bits ignored (R2)
        wr(AW'(CA), 8'h7F);
        expect_out("R2 low bits ignored", 1'b0, 1'b1, 8'h40);
        wr(AW'(CA), 8'hC0);
        expect_out("R6 locked edge", 1'b0, 1'b1, 8'h40);

        // R7 special mode writes edge-select despite lock
        mode_special = 1;
        wr(AW'(CA), 8'hC0);
        mode_special = 0;
        expect_out("R7 special write", 1'b0, 1'b1, 8'hC0);
        wr(AW'(CA), 8'h40);
        expect_out("R6 still locked", 1'b0, 1'b1, 8'hC0);

        // R4 edge mode
        pin_n = 0;
        step(STG);
        expect_out("R4 before latch", 1'b0, 1'b0, 8'h00);
        step(1);
        expect_out("R4 latched", 1'b1, 1'b0, 8'h00);
        pin_n = 1;
        step(STG + 2);
        expect_out("R4 sticky", 1'b1, 1'b0, 8'h00);

        // R5 ack clears
        ack1();
        expect_out("R5 ack clears", 1'b0, 1'b0, 8'h00);

        // R5 edge beats ack in the same cycle
        pin_n = 0;
        step(STG + 1);
        expect_out("R5 relatch", 1'b1, 1'b0, 8'h00);
        pin_n = 1;
        step(STG + 2);
        pin_n = 0;
        step(STG);
        ack1();
        expect_out("R5 edge wins", 1'b1, 1'b0, 8'h00);
        ack1();
        expect_out("R5 second ack", 1'b0, 1'b0, 8'h00);

        // R8 disable while locked in normal mode, latch held clear
        pin_n = 1;
        step(STG + 2);
        pin_n = 0;
        step(STG + 1);
        expect_out("R8 pre latch", 1'b1, 1'b0, 8'h00);
        wr(AW'(CA), 8'h80);
        expect_out("R8 disabled", 1'b0, 1'b1, 8'h80);
        wr(AW'(CA), 8'hC0);
        expect_out("R8 latch was cleared", 1'b0, 1'b1, 8'hC0);
        pin_n = 1;
        step(STG + 2);
        wr(AW'(CA), 8'h80);
        pin_n = 0;
        step(STG + 2);
        expect_out("R8 no req when off", 1'b0, 1'b0, 8'h00);
        wr(AW'(CA), 8'hC0);
        expect_out("R8 edge ignored when off", 1'b0, 1'b0, 8'h00);

        // R9 edge->level clears latch
        pin_n = 1;
        step(STG + 2);
        pin_n = 0;
        step(STG + 1);
        expect_out("R9 latched", 1'b1, 1'b0, 8'h00);
        pin_n = 1;
        step(STG + 2);
        mode_special = 1;
        wr(AW'(CA), 8'h40);
        expect_out("R9 level pin high", 1'b0, 1'b1, 8'h40);
        wr(AW'(CA), 8'hC0);
        mode_special = 0;
        expect_out("R9 stale edge gone", 1'b0, 1'b1, 8'hC0);

        // R6 reset clears the lock
        do_reset();
        wr(AW'(CA), 8'hC0);
        expect_out("R6 after reset", 1'b0, 1'b1, 8'hC0);

        step(2);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule